// File: doc/BRIEF.md
# Posted Write Queue Controller

This block sits behind a target port on an internal bus and takes in posted write transactions meant for an external PCI-style bus. Each accepted transaction holds one slot in an address queue and one fixed-size data buffer. The beats of the transaction, each with its byte enables, are written into that buffer. Once the transaction is closed, the slot is handed to the external bus master side, which sees a request along with the address, the cycle type and the beat count. That side reads the beats out by index and pops the entry when it acknowledges completion.

For each address phase the controller chooses one of three answers: accept it, answer Retry, or decline to claim it. A single-address write is claimed only when it falls inside one of the programmable windows, each given by a base and a size. A dual-address write is claimed without any window check. A burst that runs into the end of an aligned 64-byte buffer is cut off there and the initiator is disconnected. Entries leave the block in strict arrival order.

Top module: `wr_post_queue`

## Requirements
- R1: A single-address write (`in_dac`=0) whose address lies in no window is declined. `resp_noclaim` is high for the one cycle after the address phase and the queue contents are unchanged. A window hits when size is nonzero and base <= addr < base+size.
- R2: A single-address write that hits a window while fewer than 4 entries are held gets `resp_claim` for the one cycle after the address phase. The block then takes data beats.
- R3: A dual-address write (`in_dac`=1) is claimed when fewer than 4 entries are held, whatever its address. The head entry reports it with `ext_dac`=1.
- R4: An address phase that would otherwise be claimed gets `resp_retry` for the one cycle after the address phase when 4 entries are already held, and nothing is accepted.
- R5: Beat k of an entry (k counted from 0) is stored with its data and 4-bit byte-enable mask. While that entry is at the head it is returned on `ext_rd_data`/`ext_rd_be` when `ext_rd_idx`=k.
- R6: The word offset of the start address is addr[5:2]. When a beat fills the last word of the 64-byte buffer (start offset + beats = 16) and `in_last` is low, the entry closes and `resp_disc` is high for the next cycle.
- R7: A beat with `in_last` high closes the entry. The entry's `ext_beats` equals the number of beats stored (1 to 16).
- R8: `ext_req` is high exactly when at least one closed entry is held. It rises in the cycle after the closing beat.
- R9: Entries reach the head in the order they were claimed. `ext_done` while `ext_req` is high removes the head entry at that clock edge.
- R10: After reset no entry is held and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base | input | NUM_WIN*AW | Base address of each window |
| win_size | input | NUM_WIN*AW | Size in bytes of each window (0 disables it) |
| in_valid | input | 1 | Address phase strobe |
| in_dac | input | 1 | Address phase is a dual-address cycle |
| in_addr | input | AW | Write start address |
| in_beat_valid | input | 1 | Data beat strobe |
| in_data | input | DW | Beat data |
| in_be | input | DW/8 | Beat byte enables |
| in_last | input | 1 | Final beat of the transaction |
| resp_claim | output | 1 | Address phase accepted |
| resp_retry | output | 1 | Address phase answered with Retry |
| resp_noclaim | output | 1 | Address phase not claimed |
| resp_disc | output | 1 | Initiator disconnected at buffer end |
| ext_req | output | 1 | A closed entry waits for the external side |
| ext_addr | output | AW | Head entry address |
| ext_dac | output | 1 | Head entry is dual-address |
| ext_beats | output | log2(BEATS)+1 | Head entry beat count |
| ext_rd_idx | input | log2(BEATS) | Beat index to read from the head buffer |
| ext_rd_data | output | DW | Head buffer data at `ext_rd_idx` |
| ext_rd_be | output | DW/8 | Head buffer byte enables at `ext_rd_idx` |
| ext_done | input | 1 | External side completed the head entry |

## Verification
All four response flags are registered. Each one appears in the cycle after the clock edge that samples the address phase or the closing beat, and lasts for that single cycle. `ext_req`, `ext_addr`, `ext_dac` and `ext_beats` change one edge after a closing beat or a completed pop. `ext_rd_data` follows `ext_rd_idx` within the same cycle. The bench advances its behavioural queue model at each rising edge using the inputs applied half a cycle earlier. It then compares every output at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/wpq_pkg.sv
package wpq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } wpq_mode_e;
endpackage

// File: rtl/wpq_win.sv
module wpq_win #(
    parameter int AW      = 32,
    parameter int NUM_WIN = 2
) (
    input  logic [AW-1:0]              addr,
    input  logic [NUM_WIN-1:0][AW-1:0] base,
    input  logic [NUM_WIN-1:0][AW-1:0] size,
    output logic                       hit
);
    logic [NUM_WIN-1:0] hit_vec;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [AW-1:0] delta;
        assign delta      = addr - base[g];
        assign hit_vec[g] = (size[g] != '0) && (addr >= base[g]) && (delta < size[g]);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/wpq_buf.sv
module wpq_buf #(
    parameter int DEPTH = 4,
    parameter int BEATS = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  logic [$clog2(BEATS)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [DW/8-1:0]          wr_be,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr,
    input  logic [$clog2(BEATS)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [DW/8-1:0]          rd_be
);
    localparam int BW = DW / 8;

    logic [DW+BW-1:0] mem_q [DEPTH][BEATS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_ptr][wr_idx] <= {wr_be, wr_data};
        end
    end

    assign {rd_be, rd_data} = mem_q[rd_ptr][rd_idx];
endmodule

// File: rtl/wr_post_queue.sv
module wr_post_queue
    import wpq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int NUM_WIN = 2,
    parameter int DEPTH   = 4,
    parameter int BEATS   = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WIN-1:0][AW-1:0]       win_base,
    input  logic [NUM_WIN-1:0][AW-1:0]       win_size,
    input  logic                             in_valid,
    input  logic                             in_dac,
    input  logic [AW-1:0]                    in_addr,
    input  logic                             in_beat_valid,
    input  logic [DW-1:0]                    in_data,
    input  logic [DW/8-1:0]                  in_be,
    input  logic                             in_last,
    output logic                             resp_claim,
    output logic                             resp_retry,
    output logic                             resp_noclaim,
    output logic                             resp_disc,
    output logic                             ext_req,
    output logic [AW-1:0]                    ext_addr,
    output logic                             ext_dac,
    output logic [$clog2(BEATS):0]           ext_beats,
    input  logic [$clog2(BEATS)-1:0]         ext_rd_idx,
    output logic [DW-1:0]                    ext_rd_data,
    output logic [DW/8-1:0]                  ext_rd_be,
    input  logic                             ext_done
);
    localparam int BW   = DW / 8;
    localparam int LSB  = $clog2(BW);
    localparam int IDXW = $clog2(BEATS);
    localparam int NW   = IDXW + 1;
    localparam int PTRW = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        wpq_mode_e                   mode;
        logic [PTRW-1:0]             head;
        logic [PTRW-1:0]             tail;
        logic [CNTW-1:0]             count;
        logic [NW-1:0]               nbeat;
        logic [IDXW-1:0]             off;
        logic [DEPTH-1:0][AW-1:0]    addr;
        logic [DEPTH-1:0]            dac;
        logic [DEPTH-1:0][NW-1:0]    beats;
        logic                        claim;
        logic                        retry;
        logic                        noclaim;
        logic                        disc;
    } ctl_t;

    ctl_t s_d, s_q;

    logic win_hit;
    logic wr_en;
    logic commit;
    logic pop;
    logic at_bnd;
    logic idle;
    logic [CNTW-1:0] occ;

    function automatic logic [PTRW-1:0] nxt(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    wpq_win #(.AW(AW), .NUM_WIN(NUM_WIN)) u_win (
        .addr (in_addr),
        .base (win_base),
        .size (win_size),
        .hit  (win_hit)
    );

    wpq_buf #(.DEPTH(DEPTH), .BEATS(BEATS), .DW(DW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (s_q.tail),
        .wr_idx  (s_q.nbeat[IDXW-1:0]),
        .wr_data (in_data),
        .wr_be   (in_be),
        .rd_ptr  (s_q.head),
        .rd_idx  (ext_rd_idx),
        .rd_data (ext_rd_data),
        .rd_be   (ext_rd_be)
    );

    always_comb begin
        s_d         = s_q;
        s_d.claim   = 1'b0;
        s_d.retry   = 1'b0;
        s_d.noclaim = 1'b0;
        s_d.disc    = 1'b0;
        wr_en       = 1'b0;
        commit      = 1'b0;
        pop         = ext_done && (s_q.count != '0);
        at_bnd      = ({1'b0, s_q.off} + s_q.nbeat) == NW'(BEATS - 1);

        case (s_q.mode)
            ST_IDLE: begin
                if (in_valid) begin
                    if (!in_dac && !win_hit) begin
                        s_d.noclaim = 1'b1;
                    end else if (s_q.count == CNTW'(DEPTH)) begin
                        s_d.retry = 1'b1;
                    end else begin
                        s_d.claim           = 1'b1;
                        s_d.mode            = ST_DATA;
                        s_d.addr[s_q.tail]  = in_addr;
                        s_d.dac[s_q.tail]   = in_dac;
                        s_d.nbeat           = '0;
                        s_d.off             = in_addr[LSB +: IDXW];
                    end
                end
            end
            default: begin
                if (in_beat_valid) begin
                    wr_en     = 1'b1;
                    s_d.nbeat = s_q.nbeat + 1'b1;
                    if (in_last || at_bnd) begin
                        commit               = 1'b1;
                        s_d.beats[s_q.tail]  = s_q.nbeat + 1'b1;
                        s_d.tail             = nxt(s_q.tail);
                        s_d.mode             = ST_IDLE;
                        s_d.disc             = !in_last;
                    end
                end
            end
        endcase

        if (pop) begin
            s_d.head = nxt(s_q.head);
        end

        case ({commit, pop})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle         = (s_q.mode == ST_IDLE);
    assign occ          = s_q.count;
    assign resp_claim   = s_q.claim;
    assign resp_retry   = s_q.retry;
    assign resp_noclaim = s_q.noclaim;
    assign resp_disc    = s_q.disc;
    assign ext_req      = (s_q.count != '0);
    assign ext_addr     = s_q.addr[s_q.head];
    assign ext_dac      = s_q.dac[s_q.head];
    assign ext_beats    = s_q.beats[s_q.head];
endmodule

// File: rtl/wpq_chk.sv
module wpq_chk #(
    parameter int DEPTH = 4,
    parameter int CNTW  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_dac,
    input logic            in_beat_valid,
    input logic            in_last,
    input logic            ext_done,
    input logic            ext_req,
    input logic            resp_claim,
    input logic            resp_retry,
    input logic            resp_noclaim,
    input logic            resp_disc,
    input logic            idle,
    input logic            win_hit,
    input logic [CNTW-1:0] occ,
    input logic            commit
);
    p_resp_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_claim, resp_retry, resp_noclaim, resp_disc}));

    p_noclaim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && idle && !in_dac && !win_hit) |=> resp_noclaim);

    p_retry_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && idle && (in_dac || win_hit) && occ == CNTW'(DEPTH)) |=> resp_retry);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNTW'(DEPTH));

    p_disc_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_disc |-> ($past(in_beat_valid) && !$past(in_last)));

    p_req_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ext_req);

    p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_done && ext_req && !commit) |=> (occ == $past(occ) - 1'b1));
endmodule

bind wr_post_queue wpq_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_dac        (in_dac),
    .in_beat_valid (in_beat_valid),
    .in_last       (in_last),
    .ext_done      (ext_done),
    .ext_req       (ext_req),
    .resp_claim    (resp_claim),
    .resp_retry    (resp_retry),
    .resp_noclaim  (resp_noclaim),
    .resp_disc     (resp_disc),
    .idle          (idle),
    .win_hit       (win_hit),
    .occ           (occ),
    .commit        (commit)
);

// File: tb/wr_post_queue_tb.sv
module wr_post_queue_tb;
    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0][31:0]  win_base;
    logic [1:0][31:0]  win_size;
    logic              in_valid = 1'b0, in_dac = 1'b0, in_beat_valid = 1'b0, in_last = 1'b0;
    logic [31:0]       in_addr = '0, in_data = '0;
    logic [3:0]        in_be = '0;
    logic              resp_claim, resp_retry, resp_noclaim, resp_disc;
    logic              ext_req, ext_dac;
    logic [31:0]       ext_addr, ext_rd_data;
    logic [4:0]        ext_beats;
    logic [3:0]        ext_rd_idx = '0;
    logic [3:0]        ext_rd_be;
    logic              ext_done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign win_base[0] = 32'h1000_0000;
    assign win_size[0] = 32'h0010_0000;
    assign win_base[1] = 32'h8000_0000;
    assign win_size[1] = 32'h0000_1000;

    wr_post_queue u_dut (
        .clk(clk), .rst_n(rst_n), .win_base(win_base), .win_size(win_size),
        .in_valid(in_valid), .in_dac(in_dac), .in_addr(in_addr),
        .in_beat_valid(in_beat_valid), .in_data(in_data), .in_be(in_be), .in_last(in_last),
        .resp_claim(resp_claim), .resp_retry(resp_retry), .resp_noclaim(resp_noclaim),
        .resp_disc(resp_disc), .ext_req(ext_req), .ext_addr(ext_addr), .ext_dac(ext_dac),
        .ext_beats(ext_beats), .ext_rd_idx(ext_rd_idx), .ext_rd_data(ext_rd_data),
        .ext_rd_be(ext_rd_be), .ext_done(ext_done)
    );

    typedef struct packed {
        logic [31:0]       a;
        logic              dac;
        logic [4:0]        n;
        logic [15:0][31:0] d;
        logic [15:0][3:0]  be;
    } ent_t;

    ent_t q[$];
    ent_t cur;
    bit   m_data = 0;
    int   m_off = 0;
    bit   e_claim = 0, e_retry = 0, e_noclaim = 0, e_disc = 0;
    bit   auto_pop = 0;
    int   cyc = 0;
    int   checks = 0, fails = 0;
    bit   done_flag = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic bit m_hit(input logic [31:0] a);
        return (a >= 32'h1000_0000 && a < 32'h1010_0000) ||
               (a >= 32'h8000_0000 && a < 32'h8000_1000);
    endfunction

    task automatic model_update();
        int  sz = q.size();
        bit  do_commit = 0;
        e_claim = 0; e_retry = 0; e_noclaim = 0; e_disc = 0;
        if (!m_data) begin
            if (in_valid) begin
                if (!in_dac && !m_hit(in_addr)) e_noclaim = 1;
                else if (sz == 4) e_retry = 1;
                else begin
                    e_claim = 1; m_data = 1;
                    cur = '0; cur.a = in_addr; cur.dac = in_dac;
                    m_off = int'(in_addr[5:2]);
                end
            end
        end else if (in_beat_valid) begin
            cur.d[cur.n]  = in_data;
            cur.be[cur.n] = in_be;
            cur.n = cur.n + 1;
            if (in_last || (m_off + int'(cur.n) == 16)) begin
                do_commit = 1; e_disc = !in_last; m_data = 0;
            end
        end
        if (ext_done && sz > 0) void'(q.pop_front());
        if (do_commit) q.push_back(cur);
    endtask

    task automatic compare();
        chk(resp_claim == e_claim, "R2/R3", "resp_claim", 64'(resp_claim), 64'(e_claim));
        chk(resp_noclaim == e_noclaim, "R1", "resp_noclaim", 64'(resp_noclaim), 64'(e_noclaim));
        chk(resp_retry == e_retry, "R4", "resp_retry", 64'(resp_retry), 64'(e_retry));
        chk(resp_disc == e_disc, "R6", "resp_disc", 64'(resp_disc), 64'(e_disc));
        chk(ext_req == (q.size() > 0), "R8", "ext_req", 64'(ext_req), 64'(q.size() > 0));
        if (q.size() > 0) begin
            chk(ext_addr == q[0].a, "R9", "ext_addr", 64'(ext_addr), 64'(q[0].a));
            chk(ext_dac == q[0].dac, "R3", "ext_dac", 64'(ext_dac), 64'(q[0].dac));
            chk(ext_beats == q[0].n, "R7", "ext_beats", 64'(ext_beats), 64'(q[0].n));
            if (5'(ext_rd_idx) < q[0].n) begin
                chk(ext_rd_data == q[0].d[ext_rd_idx], "R5", "ext_rd_data",
                    64'(ext_rd_data), 64'(q[0].d[ext_rd_idx]));
                chk(ext_rd_be == q[0].be[ext_rd_idx], "R5", "ext_rd_be",
                    64'(ext_rd_be), 64'(q[0].be[ext_rd_idx]));
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        cyc++;
        ext_rd_idx = 4'(cyc * 7);
        ext_done   = auto_pop && (cyc % 3 == 0);
    endtask

    task automatic wr(input bit dac, input logic [31:0] addr, input int n, input logic [31:0] seed);
        in_valid = 1; in_dac = dac; in_addr = addr;
        step();
        in_valid = 0; in_dac = 0;
        for (int i = 0; i < n && m_data; i++) begin
            in_beat_valid = 1;
            in_data = seed + 32'(i * 32'h0101_0101);
            in_be   = 4'hF ^ 4'(i);
            in_last = (i == n - 1);
            step();
        end
        in_beat_valid = 0; in_last = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        chk(!ext_req, "R10", "ext_req after reset", 64'(ext_req), 0);
        chk({resp_claim, resp_retry, resp_noclaim, resp_disc} == 4'b0, "R10", "responses after reset",
            64'({resp_claim, resp_retry, resp_noclaim, resp_disc}), 0);
        step();
        // R1: miss, and first byte past window 0
        wr(0, 32'h2000_0000, 2, 32'hA000_0000);
        wr(0, 32'h1010_0000, 2, 32'hA100_0000);
        // R2/R7: hit window 0, short burst
        wr(0, 32'h1000_0040, 3, 32'h1111_0000);
        // R3/R6: dual address at word offset 12, cut after 4 beats
        wr(1, 32'h0000_0030, 8, 32'h2222_0000);
        // R7: full 16 beats, last coincides with boundary
        wr(0, 32'h8000_0000, 16, 32'h3333_0000);
        // R6: window 1 at offset 14, cut after 2 beats -> queue full
        wr(0, 32'h8000_0FF8, 5, 32'h4444_0000);
        // R4: retry while full, R1 still declined while full
        wr(1, 32'h0000_1234, 2, 32'h5555_0000);
        wr(0, 32'h1000_0000, 1, 32'h6666_0000);
        wr(0, 32'h9000_0000, 1, 32'h7777_0000);
        repeat (20) step();
        // R9: drain in order
        auto_pop = 1;
        repeat (40) step();
        // R8/R9: pops interleaved with commits
        for (int k = 0; k < 12; k++) begin
            wr(k[0], 32'h1000_0000 + 32'(k * 52), 1 + (k % 9), 32'(k) << 24);
            step();
        end
        repeat (60) step();
        auto_pop = 0;
        finish_run();
    end
endmodule